// File: doc/BRIEF.md
# Keyboard and Auxiliary Controller Host Interface

This block is the host-facing half of a keyboard/pointing-device controller. A byte-wide host bus reaches three ports: a data port, a control port (written with command bytes, read as status) and a system-control port. The block holds the controller's mode byte, a self-test flag and the system-control byte. It decodes command bytes and routes data-port writes. It picks which attached device's byte the host reads, and it drives two interrupt lines, an address-line-20 gate and a one-cycle system reset request.

Each attached device appears as two byte streams with valid/ready handshakes. The inbound stream carries bytes the device has ready for the host. The outbound stream carries bytes for the device. The controller's own replies to commands leave on the keyboard outbound stream. A surrounding device model is expected to loop them back into the keyboard inbound stream.

Some commands act at once. Others arm a pending code that decides where the next data-port write goes.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the mode byte is 0x03, a status read returns 0x18, a system-control read returns 0x03, `a20_gate` is 1, both interrupts and `sys_rst_req` are 0, both outbound streams are idle and `kbd_xlate` is 0. `host_sel` encodes 0 = data, 1 = control/status, 2 = system control, 3 = unused (reads 0x00, writes ignored).
- R2: Control writes of 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending code, and a later arming command replaces an earlier one. The next data-port write is routed by that code and clears it. After 0x60 the data byte becomes the mode byte, and `kbd_xlate` follows mode bit 6.
- R3: A data-port write with nothing pending, or after 0xD2, is offered on the keyboard outbound stream. A data-port write after 0xD3 or 0xD4 is offered on the auxiliary outbound stream.
- R4: Control 0x20 queues the mode byte on the keyboard outbound stream. 0xA7 sets and 0xA8 clears mode bit 5. 0xAD sets and 0xAE clears mode bit 4.
- R5: Controls 0xA9, 0xAB and 0xC0 queue 0x00. 0xAA sets status bit 2 (sticky) and queues 0x55. 0xD0 queues the system-control byte as a system-control read would return it.
- R6: Control 0xDF sets system-control bit 1 and `a20_gate`, and 0xDD clears them. 0xFE raises `sys_rst_req` for exactly one cycle. 0xFF and any unlisted code change no state and queue nothing.
- R7: Status bit 0 and system-control bit 4 are 1 when either inbound stream is valid. Status bit 5 and system-control bit 5 are 1 only when the auxiliary stream alone is valid. These flags change one clock after the inbound valids change.
- R8: `irq_kbd` is 1 one clock after the keyboard inbound stream is valid with mode bit 0 set and mode bit 4 clear. `irq_aux` is 1 one clock after the auxiliary stream alone is valid with mode bit 1 set. Both interrupts re-evaluate one clock after a mode change.
- R9: A data-port read returns the auxiliary byte and pulses `ain_ready` when the auxiliary stream alone is valid. Otherwise it returns the keyboard byte, pulsing `kin_ready` only if that stream is valid.
- R10: A system-control write, or a data-port write after 0xD1, loads the system-control byte and drives `a20_gate` from bit 1. If bit 0 is written as 0, `sys_rst_req` pulses for one cycle.
- R11: An outbound stream holds its byte stable until it is accepted. A byte queued while the stream holds an unaccepted byte is dropped. A byte queued in the same cycle the held byte is accepted replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Port select: 0 data, 1 control/status, 2 system control |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the selected port |
| kin_valid | input | 1 | Keyboard inbound byte available |
| kin_data | input | 8 | Keyboard inbound byte |
| kin_ready | output | 1 | Keyboard inbound byte consumed |
| ain_valid | input | 1 | Auxiliary inbound byte available |
| ain_data | input | 8 | Auxiliary inbound byte |
| ain_ready | output | 1 | Auxiliary inbound byte consumed |
| kout_valid | output | 1 | Keyboard outbound byte held |
| kout_data | output | 8 | Keyboard outbound byte |
| kout_ready | input | 1 | Keyboard outbound byte accepted |
| aout_valid | output | 1 | Auxiliary outbound byte held |
| aout_data | output | 8 | Auxiliary outbound byte |
| aout_ready | input | 1 | Auxiliary outbound byte accepted |
| kbd_xlate | output | 1 | Keyboard scan-code translation enable |
| irq_kbd | output | 1 | Keyboard interrupt |
| irq_aux | output | 1 | Auxiliary interrupt |
| a20_gate | output | 1 | Address line 20 gate |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Two events can land on the keyboard outbound stream in the same cycle: the device accepting the held byte, and a host access queueing a new one. The bench first leaves a reply unaccepted and confirms that a second reply is dropped. It then raises `kout_ready` in the same cycle as a fresh data-port write. The check passes only if the old byte is consumed and the new byte is held afterwards, with neither lost nor duplicated. A second overlap is a data-port read that takes the keyboard byte while an auxiliary byte also waits. Here the bench checks that the ready pulse goes to the keyboard side only and that the status flags still show keyboard priority.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int unsigned BYTE_W = 8;

  // host port select
  typedef enum logic [1:0] {
    PORT_DATA = 2'd0,
    PORT_CTRL = 2'd1,
    PORT_SYS  = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  // pending second-byte routing
  typedef enum logic [2:0] {
    ARM_NONE   = 3'd0,
    ARM_MODE   = 3'd1,
    ARM_SYSCTL = 3'd2,
    ARM_KBUF   = 3'd3,
    ARM_ABUF   = 3'd4,
    ARM_AUXDEV = 3'd5
  } arm_e;

  // source of a controller reply byte
  typedef enum logic [1:0] {
    RSP_MODE   = 2'd0,
    RSP_ZERO   = 2'd1,
    RSP_PASS   = 2'd2,
    RSP_SYSCTL = 2'd3
  } rsp_e;

  typedef struct packed {
    logic       known;
    logic       arm_en;
    arm_e       arm;
    logic       rsp_en;
    rsp_e       rsp;
    logic       mode_set;
    logic       mode_clr;
    logic [2:0] mode_bit;
    logic       selftest;
    logic       a20_set;
    logic       a20_clr;
    logic       sys_rst;
  } cmd_act_t;

  // mode bit positions
  localparam int unsigned MODE_KIRQ  = 0;
  localparam int unsigned MODE_AIRQ  = 1;
  localparam int unsigned MODE_KDIS  = 4;
  localparam int unsigned MODE_ADIS  = 5;
  localparam int unsigned MODE_XLATE = 6;

  localparam logic [BYTE_W-1:0] MODE_RST  = 8'h03;
  localparam logic [3:0]        SYSLO_RST = 4'h3;
  localparam logic [1:0]        SYSHI_RST = 2'h0;
  localparam logic [BYTE_W-1:0] SELFTEST_PASS = 8'h55;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd,
  output cmd_act_t          act
);
  always_comb begin
    act = '0;
    act.known = 1'b1;
    case (cmd)
      8'h20: begin act.rsp_en = 1'b1; act.rsp = RSP_MODE; end
      8'h60: begin act.arm_en = 1'b1; act.arm = ARM_MODE; end
      8'hD1: begin act.arm_en = 1'b1; act.arm = ARM_SYSCTL; end
      8'hD2: begin act.arm_en = 1'b1; act.arm = ARM_KBUF; end
      8'hD3: begin act.arm_en = 1'b1; act.arm = ARM_ABUF; end
      8'hD4: begin act.arm_en = 1'b1; act.arm = ARM_AUXDEV; end
      8'hA7: begin act.mode_set = 1'b1; act.mode_bit = 3'(MODE_ADIS); end
      8'hA8: begin act.mode_clr = 1'b1; act.mode_bit = 3'(MODE_ADIS); end
      8'hAD: begin act.mode_set = 1'b1; act.mode_bit = 3'(MODE_KDIS); end
      8'hAE: begin act.mode_clr = 1'b1; act.mode_bit = 3'(MODE_KDIS); end
      8'hA9, 8'hAB, 8'hC0: begin act.rsp_en = 1'b1; act.rsp = RSP_ZERO; end
      8'hAA: begin act.selftest = 1'b1; act.rsp_en = 1'b1; act.rsp = RSP_PASS; end
      8'hD0: begin act.rsp_en = 1'b1; act.rsp = RSP_SYSCTL; end
      8'hDF: act.a20_set = 1'b1;
      8'hDD: act.a20_clr = 1'b1;
      8'hFE: act.sys_rst = 1'b1;
      default: act.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/kbc_out_slot.sv
module kbc_out_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  logic         valid_q, valid_d;
  logic [W-1:0] data_q, data_d;
  logic         take;

  always_comb begin
    take    = load && (!valid_q || out_ready);
    valid_d = valid_q;
    data_d  = data_q;
    if (take) begin
      valid_d = 1'b1;
      data_d  = load_data;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (take) data_q <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/kbc_flags.sv
module kbc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic kin_valid,
  input  logic ain_valid,
  input  logic kirq_en,
  input  logic airq_en,
  input  logic kbd_dis,
  output logic obf,
  output logic aux_obf,
  output logic irq_kbd,
  output logic irq_aux
);
  logic obf_d, aobf_d, ik_d, ia_d;
  logic obf_q, aobf_q, ik_q, ia_q;

  always_comb begin
    obf_d  = kin_valid || ain_valid;
    aobf_d = !kin_valid && ain_valid;
    ik_d   = kin_valid && kirq_en && !kbd_dis;
    ia_d   = aobf_d && airq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_q  <= 1'b0;
      aobf_q <= 1'b0;
      ik_q   <= 1'b0;
      ia_q   <= 1'b0;
    end else begin
      obf_q  <= obf_d;
      aobf_q <= aobf_d;
      ik_q   <= ik_d;
      ia_q   <= ia_d;
    end
  end

  assign obf     = obf_q;
  assign aux_obf = aobf_q;
  assign irq_kbd = ik_q;
  assign irq_aux = ia_q;
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              kin_valid,
  input  logic [BYTE_W-1:0] kin_data,
  output logic              kin_ready,
  input  logic              ain_valid,
  input  logic [BYTE_W-1:0] ain_data,
  output logic              ain_ready,
  output logic              kout_valid,
  output logic [BYTE_W-1:0] kout_data,
  input  logic              kout_ready,
  output logic              aout_valid,
  output logic [BYTE_W-1:0] aout_data,
  input  logic              aout_ready,
  output logic              kbd_xlate,
  output logic              irq_kbd,
  output logic              irq_aux,
  output logic              a20_gate,
  output logic              sys_rst_req
);
  logic [BYTE_W-1:0] mode_q, mode_d;
  logic              st_q, st_d;
  logic [3:0]        slo_q, slo_d;
  logic [1:0]        shi_q, shi_d;
  arm_e              pend_q, pend_d;
  logic              rreq_q, rreq_d;

  logic              obf, aux_obf;
  logic [BYTE_W-1:0] sys_view, stat_view;
  logic              wr_data, wr_ctrl, wr_sys, rd_data, aux_only;
  logic              kload, aload;
  logic [BYTE_W-1:0] kbyte;
  cmd_act_t          act;

  kbc_cmd_decode u_dec (.cmd(host_wdata), .act(act));

  assign wr_data  = host_wr && (port_e'(host_sel) == PORT_DATA);
  assign wr_ctrl  = host_wr && (port_e'(host_sel) == PORT_CTRL);
  assign wr_sys   = host_wr && (port_e'(host_sel) == PORT_SYS);
  assign rd_data  = host_rd && (port_e'(host_sel) == PORT_DATA);
  assign aux_only = ain_valid && !kin_valid;

  assign sys_view  = {shi_q, aux_obf, obf, slo_q};
  assign stat_view = {2'b00, aux_obf, 1'b1, 1'b1, st_q, 1'b0, obf};

  // next state
  always_comb begin
    mode_d = mode_q;
    st_d   = st_q;
    slo_d  = slo_q;
    shi_d  = shi_q;
    pend_d = pend_q;
    rreq_d = 1'b0;
    kload  = 1'b0;
    aload  = 1'b0;
    kbyte  = host_wdata;

    if (wr_ctrl && act.known) begin
      if (act.arm_en)   pend_d = act.arm;
      if (act.mode_set) mode_d[act.mode_bit] = 1'b1;
      if (act.mode_clr) mode_d[act.mode_bit] = 1'b0;
      if (act.selftest) st_d = 1'b1;
      if (act.a20_set)  slo_d[1] = 1'b1;
      if (act.a20_clr)  slo_d[1] = 1'b0;
      if (act.sys_rst)  rreq_d = 1'b1;
      if (act.rsp_en) begin
        kload = 1'b1;
        case (act.rsp)
          RSP_MODE:   kbyte = mode_q;
          RSP_ZERO:   kbyte = '0;
          RSP_PASS:   kbyte = SELFTEST_PASS;
          RSP_SYSCTL: kbyte = sys_view;
          default:    kbyte = '0;
        endcase
      end
    end

    if (wr_data) begin
      pend_d = ARM_NONE;
      case (pend_q)
        ARM_MODE:   mode_d = host_wdata;
        ARM_SYSCTL: begin
          slo_d  = host_wdata[3:0];
          shi_d  = host_wdata[7:6];
          rreq_d = !host_wdata[0];
        end
        ARM_ABUF, ARM_AUXDEV: aload = 1'b1;
        default:    kload = 1'b1;
      endcase
    end

    if (wr_sys) begin
      slo_d  = host_wdata[3:0];
      shi_d  = host_wdata[7:6];
      rreq_d = !host_wdata[0];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      st_q   <= 1'b0;
      slo_q  <= SYSLO_RST;
      shi_q  <= SYSHI_RST;
      pend_q <= ARM_NONE;
      rreq_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      st_q   <= st_d;
      slo_q  <= slo_d;
      shi_q  <= shi_d;
      pend_q <= pend_d;
      rreq_q <= rreq_d;
    end
  end

  kbc_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .kin_valid(kin_valid), .ain_valid(ain_valid),
    .kirq_en(mode_q[MODE_KIRQ]), .airq_en(mode_q[MODE_AIRQ]),
    .kbd_dis(mode_q[MODE_KDIS]),
    .obf(obf), .aux_obf(aux_obf),
    .irq_kbd(irq_kbd), .irq_aux(irq_aux)
  );

  kbc_out_slot #(.W(BYTE_W)) u_kslot (
    .clk(clk), .rst_n(rst_n), .load(kload), .load_data(kbyte),
    .out_valid(kout_valid), .out_data(kout_data), .out_ready(kout_ready)
  );

  kbc_out_slot #(.W(BYTE_W)) u_aslot (
    .clk(clk), .rst_n(rst_n), .load(aload), .load_data(host_wdata),
    .out_valid(aout_valid), .out_data(aout_data), .out_ready(aout_ready)
  );

  // host read path
  always_comb begin
    case (port_e'(host_sel))
      PORT_DATA: host_rdata = aux_only ? ain_data : kin_data;
      PORT_CTRL: host_rdata = stat_view;
      PORT_SYS:  host_rdata = sys_view;
      default:   host_rdata = '0;
    endcase
  end

  assign kin_ready   = rd_data && kin_valid;
  assign ain_ready   = rd_data && aux_only;
  assign kbd_xlate   = mode_q[MODE_XLATE];
  assign a20_gate    = slo_q[1];
  assign sys_rst_req = rreq_q;
endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_rd,
  input logic       kin_valid,
  input logic       kin_ready,
  input logic       ain_ready,
  input logic       kout_valid,
  input logic [7:0] kout_data,
  input logic       kout_ready,
  input logic       aout_valid,
  input logic [7:0] aout_data,
  input logic       aout_ready,
  input logic       irq_kbd,
  input logic       irq_aux,
  input logic       sys_rst_req
);
  AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(host_wr)); // R6
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_kbd && irq_aux)); // R8
  AST_IRQ_KBD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_kbd |-> $past(kin_valid)); // R8
  AST_IRQ_AUX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_aux |-> !$past(kin_valid)); // R8
  AST_READY_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kin_ready, ain_ready})); // R9
  AST_READY_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (kin_ready || ain_ready) |-> host_rd); // R9
  AST_KOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (kout_valid && !kout_ready) |=> (kout_valid && $stable(kout_data))); // R11
  AST_AOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (aout_valid && !aout_ready) |=> (aout_valid && $stable(aout_data))); // R11
endmodule

bind kbc_host_if kbc_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .kin_valid(kin_valid), .kin_ready(kin_ready), .ain_ready(ain_ready),
  .kout_valid(kout_valid), .kout_data(kout_data), .kout_ready(kout_ready),
  .aout_valid(aout_valid), .aout_data(aout_data), .aout_ready(aout_ready),
  .irq_kbd(irq_kbd), .irq_aux(irq_aux), .sys_rst_req(sys_rst_req)
);

// File: tb/tb_kbc_host_if.sv
module tb_kbc_host_if;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] host_sel;
  logic       host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic       kin_valid, kin_ready, ain_valid, ain_ready;
  logic [7:0] kin_data, ain_data;
  logic       kout_valid, kout_ready, aout_valid, aout_ready;
  logic [7:0] kout_data, aout_data;
  logic       kbd_xlate, irq_kbd, irq_aux, a20_gate, sys_rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  kbc_host_if dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v,
                    output logic kr, output logic ar);
    host_sel = s; host_rd = 1'b1;
    #1;
    v = host_rdata; kr = kin_ready; ar = ain_ready;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rdv(input logic [1:0] s, input string tag, input logic [7:0] exp);
    logic [7:0] v; logic kr, ar;
    rd(s, v, kr, ar);
    chk(tag, v, exp);
  endtask

  task automatic take_k(input string tag, input logic [7:0] exp);
    chk({tag, " kout_valid"}, {7'd0, kout_valid}, 8'd1);
    chk({tag, " kout_data"}, kout_data, exp);
    kout_ready = 1'b1;
    @(negedge clk);
    kout_ready = 1'b0;
    chk({tag, " kout drained"}, {7'd0, kout_valid}, 8'd0);
  endtask

  task automatic take_a(input string tag, input logic [7:0] exp);
    chk({tag, " aout_valid"}, {7'd0, aout_valid}, 8'd1);
    chk({tag, " aout_data"}, aout_data, exp);
    aout_ready = 1'b1;
    @(negedge clk);
    aout_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 status", 8'h00, 8'h00);
    rdv(2'd1, "R1 status", 8'h18);
    rdv(2'd2, "R1 sysctl", 8'h03);
    rdv(2'd3, "R1 unused port", 8'h00);
    chk("R1 a20", {7'd0, a20_gate}, 8'd1);
    chk("R1 irqs", {6'd0, irq_kbd, irq_aux}, 8'd0);
    chk("R1 rst req", {7'd0, sys_rst_req}, 8'd0);
    chk("R1 streams idle", {6'd0, kout_valid, aout_valid}, 8'd0);
    chk("R1 xlate", {7'd0, kbd_xlate}, 8'd0);
    wr(2'd1, 8'h20);
    take_k("R1 R4 mode readback", 8'h03);
  endtask

  task automatic t_mode_write;
    wr(2'd1, 8'h60);
    chk("R2 armed no output", {6'd0, kout_valid, aout_valid}, 8'd0);
    wr(2'd0, 8'h47);
    chk("R2 mode write no output", {7'd0, kout_valid}, 8'd0);
    chk("R2 xlate from bit6", {7'd0, kbd_xlate}, 8'd1);
    wr(2'd1, 8'h20);
    take_k("R2 mode value", 8'h47);
    wr(2'd0, 8'h99);
    take_k("R2 pending cleared", 8'h99);
    wr(2'd1, 8'h60);
    wr(2'd0, 8'h03);
    chk("R2 xlate off", {7'd0, kbd_xlate}, 8'd0);
  endtask

  task automatic t_routing;
    wr(2'd1, 8'hD2); wr(2'd0, 8'h12);
    chk("R3 D2 not aux", {7'd0, aout_valid}, 8'd0);
    take_k("R3 D2 to kbd", 8'h12);
    wr(2'd1, 8'hD3); wr(2'd0, 8'h34);
    chk("R3 D3 not kbd", {7'd0, kout_valid}, 8'd0);
    take_a("R3 D3 to aux", 8'h34);
    wr(2'd1, 8'hD4); wr(2'd0, 8'h56);
    take_a("R3 D4 to aux", 8'h56);
    wr(2'd1, 8'hD3); wr(2'd1, 8'hD2); wr(2'd0, 8'h77);
    chk("R2 rearm replaces", {7'd0, aout_valid}, 8'd0);
    take_k("R2 rearm to kbd", 8'h77);
  endtask

  task automatic t_immediate;
    wr(2'd1, 8'hA7); wr(2'd1, 8'h20); take_k("R4 A7 bit5", 8'h23);
    wr(2'd1, 8'hA8); wr(2'd1, 8'h20); take_k("R4 A8 bit5", 8'h03);
    wr(2'd1, 8'hAD); wr(2'd1, 8'h20); take_k("R4 AD bit4", 8'h13);
    wr(2'd1, 8'hAE); wr(2'd1, 8'h20); take_k("R4 AE bit4", 8'h03);
    wr(2'd1, 8'hA9); take_k("R5 A9", 8'h00);
    wr(2'd1, 8'hAB); take_k("R5 AB", 8'h00);
    wr(2'd1, 8'hC0); take_k("R5 C0", 8'h00);
    wr(2'd1, 8'hAA); take_k("R5 AA", 8'h55);
    rdv(2'd1, "R5 selftest bit", 8'h1C);
    wr(2'd1, 8'hD0); take_k("R5 D0", 8'h03);
  endtask

  task automatic t_a20;
    wr(2'd1, 8'hDD);
    chk("R6 DD a20", {7'd0, a20_gate}, 8'd0);
    rdv(2'd2, "R6 DD sysctl", 8'h01);
    wr(2'd1, 8'hDF);
    chk("R6 DF a20", {7'd0, a20_gate}, 8'd1);
    wr(2'd1, 8'hFE);
    chk("R6 FE pulse", {7'd0, sys_rst_req}, 8'd1);
    @(negedge clk);
    chk("R6 FE one cycle", {7'd0, sys_rst_req}, 8'd0);
    wr(2'd1, 8'hFF);
    wr(2'd1, 8'h33);
    chk("R6 ignored no rst", {7'd0, sys_rst_req}, 8'd0);
    chk("R6 ignored no out", {6'd0, kout_valid, aout_valid}, 8'd0);
    rdv(2'd1, "R6 ignored status", 8'h1C);
    rdv(2'd2, "R6 ignored sysctl", 8'h03);
    wr(2'd0, 8'h5A);
    take_k("R6 ignored left no pending", 8'h5A);
    wr(2'd1, 8'h20);
    take_k("R6 ignored mode", 8'h03);
  endtask

  task automatic t_sysctl;
    wr(2'd2, 8'h01);
    chk("R10 a20 low", {7'd0, a20_gate}, 8'd0);
    chk("R10 no rst", {7'd0, sys_rst_req}, 8'd0);
    rdv(2'd2, "R10 readback", 8'h01);
    wr(2'd2, 8'h02);
    chk("R10 rst on bit0 low", {7'd0, sys_rst_req}, 8'd1);
    chk("R10 a20 high", {7'd0, a20_gate}, 8'd1);
    @(negedge clk);
    chk("R10 rst one cycle", {7'd0, sys_rst_req}, 8'd0);
    wr(2'd1, 8'hD1); wr(2'd0, 8'h00);
    chk("R10 D1 rst", {7'd0, sys_rst_req}, 8'd1);
    chk("R10 D1 a20", {7'd0, a20_gate}, 8'd0);
    chk("R10 D1 no out", {7'd0, kout_valid}, 8'd0);
    wr(2'd2, 8'h03);
    rdv(2'd2, "R10 restore", 8'h03);
  endtask

  task automatic t_flags;
    logic [7:0] v; logic kr, ar;
    kin_data = 8'hA1; kin_valid = 1'b1;
    #1;
    chk("R7 flag delayed", {7'd0, irq_kbd}, 8'd0);
    @(negedge clk);
    rdv(2'd1, "R7 kbd status", 8'h1D);
    rdv(2'd2, "R7 kbd sysctl", 8'h13);
    chk("R8 kbd irq", {6'd0, irq_kbd, irq_aux}, 8'd2);
    ain_data = 8'hB2; ain_valid = 1'b1;
    @(negedge clk);
    rdv(2'd1, "R7 both status", 8'h1D);
    chk("R8 kbd priority irq", {6'd0, irq_kbd, irq_aux}, 8'd2);
    rd(2'd0, v, kr, ar);
    chk("R9 kbd byte first", v, 8'hA1);
    chk("R9 kbd ready only", {6'd0, kr, ar}, 8'd2);
    kin_valid = 1'b0;
    @(negedge clk);
    rdv(2'd1, "R7 aux status", 8'h3D);
    rdv(2'd2, "R7 aux sysctl", 8'h33);
    chk("R8 aux irq", {6'd0, irq_kbd, irq_aux}, 8'd1);
    rd(2'd0, v, kr, ar);
    chk("R9 aux byte", v, 8'hB2);
    chk("R9 aux ready", {6'd0, kr, ar}, 8'd1);
    wr(2'd1, 8'h60); wr(2'd0, 8'h00);
    @(negedge clk);
    chk("R8 aux irq gated", {7'd0, irq_aux}, 8'd0);
    ain_valid = 1'b0; kin_valid = 1'b1;
    wr(2'd1, 8'h60); wr(2'd0, 8'h03);
    @(negedge clk);
    chk("R8 kbd irq restored", {7'd0, irq_kbd}, 8'd1);
    wr(2'd1, 8'hAD);
    chk("R8 disable one clock later", {7'd0, irq_kbd}, 8'd1);
    @(negedge clk);
    chk("R8 kbd disabled", {7'd0, irq_kbd}, 8'd0);
    wr(2'd1, 8'hAE);
    @(negedge clk);
    chk("R8 kbd enabled", {7'd0, irq_kbd}, 8'd1);
    kin_valid = 1'b0;
    rd(2'd0, v, kr, ar);
    chk("R9 empty no ready", {6'd0, kr, ar}, 8'd0);
    @(negedge clk);
    rdv(2'd1, "R7 cleared", 8'h1C);
  endtask

  task automatic t_slot;
    wr(2'd1, 8'hA9);
    wr(2'd1, 8'hAA);
    chk("R11 held byte kept", kout_data, 8'h00);
    @(negedge clk);
    chk("R11 still held", kout_data, 8'h00);
    kout_ready = 1'b1;
    wr(2'd0, 8'h66);
    kout_ready = 1'b0;
    take_k("R11 handoff replace", 8'h66);
    chk("R11 no duplicate", {7'd0, kout_valid}, 8'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_sel = 2'd0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = 8'h00; kin_valid = 1'b0; kin_data = 8'h00;
    ain_valid = 1'b0; ain_data = 8'h00; kout_ready = 1'b0; aout_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mode_write;
    t_routing;
    t_immediate;
    t_a20;
    t_sysctl;
    t_flags;
    t_slot;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule